// File: doc/BRIEF.md
# Core Local Reset and Debug Pause Controller

This controller sits next to a processor pipeline and manages two requests that must not disturb the rest of the chip. The first is a local reset request. When it arrives, the controller tells the pipeline to stop taking new work and waits until the work already in flight has finished. Only then does it enter a held reset state. While the request stays high, the controller repeats a one-cycle acknowledge and a dummy read of a fixed reset address at a fixed interval, and it ignores the data that comes back. When the request drops, it leaves reset and tells the fetch stage to restart from the reset address.

The second request is a debug pause. It sends execution to the break address and acknowledges the debugger. While an external debugger holds the core, a local reset request is deferred. The request is honoured as soon as control is handed back, whether for one single step or for a full resume. A new debug request has no effect while the core is already paused. The global reset, active low and asynchronous, overrides everything.

Top module: `core_hold_ctrl`

## Requirements
- R1: Asserting the global reset (rst_ni low) immediately drives hold_o, rst_taken_o, rd_req_o, fetch_restart_o, dbg_ack_o and break_jump_o low, without waiting for a clock edge.
- R2: rst_req_i sampled high while running and not frozen raises hold_o from the next cycle. Frozen means dbg_paused_i high with step_i low. hold_o then stays high while rst_req_i remains high.
- R3: While draining, the first edge that samples pipe_empty_i high enters reset. rst_taken_o is high in the first cycle of reset, for exactly one cycle.
- R4: While rst_req_i stays high in reset, rst_taken_o repeats as a one-cycle pulse every PERIOD cycles, counted from the entry cycle.
- R5: rd_req_o is high in every cycle in which rst_taken_o is high, and rd_addr_o always equals RST_ADDR. A request is accepted in a cycle where rd_ack_i is high; otherwise it is held into the next cycle while the core stays in reset.
- R6: An edge that samples rst_req_i low during reset returns the core to running. In the next cycle, hold_o and rd_req_o are low and fetch_restart_o is high for exactly one cycle.
- R7: rst_req_i has no effect while frozen: hold_o stays low.
- R8: A deferred rst_req_i is acted on at the first edge where step_i is high or dbg_paused_i is low.
- R9: dbg_req_i sampled high while running with dbg_paused_i low gives, in the next cycle, a one-cycle break_jump_o pulse. dbg_ack_o rises in that same cycle and stays high until an edge samples dbg_req_i low.
- R10: dbg_req_i has no effect while dbg_paused_i is high: dbg_ack_o and break_jump_o stay low.
- R11: If rst_req_i drops during the drain, the core returns to running. hold_o falls in the next cycle, with no rst_taken_o and no fetch_restart_o.
- R12: When rst_req_i and dbg_req_i are sampled high together while running, the reset wins: hold_o rises and dbg_ack_o stays low. hold_o and dbg_ack_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| rst_req_i | input | 1 | Local reset request |
| dbg_req_i | input | 1 | Debug pause request |
| pipe_empty_i | input | 1 | Pipeline holds no instruction in flight |
| dbg_paused_i | input | 1 | External debugger currently holds the core |
| step_i | input | 1 | Debugger releases the core for one step |
| rd_ack_i | input | 1 | Memory accepts the dummy read this cycle |
| rst_taken_o | output | 1 | Reset entry / periodic reset acknowledge pulse |
| dbg_ack_o | output | 1 | Debug pause acknowledge |
| hold_o | output | 1 | Pipeline must issue no new work and drain |
| break_jump_o | output | 1 | Redirect execution to the break address |
| fetch_restart_o | output | 1 | Restart fetch at the reset address |
| rd_req_o | output | 1 | Dummy read request |
| rd_addr_o | output | ADDR_W | Dummy read address (RST_ADDR) |

## Verification
Some rules hold cycle by cycle and are asserted on every cycle: the one-cycle width of the reset acknowledge, break and restart pulses; the mutual exclusion of hold and debug acknowledge; that a frozen core never enters the drain and that a paused core never acknowledges a debug request; that a held read stays requested until accepted; and that the hold follows the level of the reset request. The spacing of the periodic acknowledge and the read handshake across several periods come only from the bench scenarios. So do the sweep over drain lengths, the deferral and release through single step, and the asynchronous global reset taken mid-reset.

// File: rtl/core_hold_pkg.sv
package core_hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_RESET = 2'd2,
    ST_BRK   = 2'd3
  } hold_state_e;
endpackage

// File: rtl/core_hold_fsm.sv
module core_hold_fsm
  import core_hold_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rst_req_i,
  input  logic        dbg_req_i,
  input  logic        pipe_empty_i,
  input  logic        dbg_paused_i,
  input  logic        step_i,
  output hold_state_e state_o,
  output logic        restart_o,
  output logic        brk_o
);
  hold_state_e state_q, state_d;
  logic        restart_q, restart_d;
  logic        brk_q, brk_d;
  logic        frozen;

  // Debugger holds the core unless it grants a single step.
  assign frozen = dbg_paused_i & ~step_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (rst_req_i && !frozen)            state_d = ST_DRAIN;
        else if (dbg_req_i && !dbg_paused_i) state_d = ST_BRK;
      end
      ST_DRAIN: begin
        if (!rst_req_i)        state_d = ST_RUN;
        else if (pipe_empty_i) state_d = ST_RESET;
      end
      ST_RESET: if (!rst_req_i) state_d = ST_RUN;
      ST_BRK:   if (!dbg_req_i) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
    restart_d = (state_q == ST_RESET) && (state_d == ST_RUN);
    brk_d     = (state_q == ST_RUN)   && (state_d == ST_BRK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      restart_q <= 1'b0;
      brk_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
      brk_q     <= brk_d;
    end
  end

  assign state_o   = state_q;
  assign restart_o = restart_q;
  assign brk_o     = brk_q;
endmodule

// File: rtl/core_hold_timer.sv
module core_hold_timer #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_rst_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Count only while in reset; park at zero otherwise so entry ticks at once.
  assign cnt_en = in_rst_i | (cnt_q != '0);

  always_comb begin
    if (!in_rst_i)         cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign tick_o = in_rst_i && (cnt_q == '0);
endmodule

// File: rtl/core_hold_rd.sv
module core_hold_rd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stay_i,
  input  logic ack_i,
  output logic req_o
);
  logic pend_q, pend_d;
  logic pend_en;

  assign req_o   = tick_i | pend_q;
  assign pend_d  = req_o & ~ack_i & stay_i;
  assign pend_en = req_o | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/core_hold_ctrl.sv
module core_hold_ctrl
  import core_hold_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0,
  parameter int unsigned PERIOD   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_req_i,
  input  logic              dbg_req_i,
  input  logic              pipe_empty_i,
  input  logic              dbg_paused_i,
  input  logic              step_i,
  input  logic              rd_ack_i,
  output logic              rst_taken_o,
  output logic              dbg_ack_o,
  output logic              hold_o,
  output logic              break_jump_o,
  output logic              fetch_restart_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  hold_state_e state;
  logic        in_rst;
  logic        tick;

  core_hold_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_req_i    (rst_req_i),
    .dbg_req_i    (dbg_req_i),
    .pipe_empty_i (pipe_empty_i),
    .dbg_paused_i (dbg_paused_i),
    .step_i       (step_i),
    .state_o      (state),
    .restart_o    (fetch_restart_o),
    .brk_o        (break_jump_o)
  );

  assign in_rst = (state == ST_RESET);

  core_hold_timer #(.PERIOD(PERIOD)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_rst_i (in_rst),
    .tick_o   (tick)
  );

  core_hold_rd u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .stay_i (in_rst & rst_req_i),
    .ack_i  (rd_ack_i),
    .req_o  (rd_req_o)
  );

  assign rst_taken_o = tick;
  assign rd_addr_o   = RST_ADDR;
  assign hold_o      = (state == ST_DRAIN) || in_rst;
  assign dbg_ack_o   = (state == ST_BRK);
endmodule

// File: rtl/core_hold_ctrl_chk.sv
module core_hold_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_req_i,
  input logic dbg_req_i,
  input logic dbg_paused_i,
  input logic step_i,
  input logic rd_ack_i,
  input logic rst_taken_o,
  input logic dbg_ack_o,
  input logic hold_o,
  input logic break_jump_o,
  input logic fetch_restart_o,
  input logic rd_req_o
);
  AST_TAKEN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_taken_o |=> !rst_taken_o); // R3
  AST_TAKEN_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_taken_o |-> hold_o); // R4
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && rst_req_i) |=> hold_o); // R2
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !rst_req_i) |=> (!hold_o && !rd_req_o)); // R6
  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_restart_o |-> (!hold_o && $past(hold_o))); // R6
  AST_FROZEN_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && dbg_paused_i && !step_i) |=> !hold_o); // R7
  AST_RD_ON_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_taken_o |-> rd_req_o); // R5
  AST_RD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && rst_req_i) |=> rd_req_o); // R5
  AST_BRK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_jump_o |-> (dbg_ack_o && !$past(dbg_ack_o))); // R9
  AST_DBG_ACK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ack_o && dbg_req_i) |=> dbg_ack_o); // R9
  AST_PAUSED_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_ack_o && dbg_paused_i) |=> !dbg_ack_o); // R10
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_o && dbg_ack_o)); // R12
endmodule

bind core_hold_ctrl core_hold_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rst_req_i       (rst_req_i),
  .dbg_req_i       (dbg_req_i),
  .dbg_paused_i    (dbg_paused_i),
  .step_i          (step_i),
  .rd_ack_i        (rd_ack_i),
  .rst_taken_o     (rst_taken_o),
  .dbg_ack_o       (dbg_ack_o),
  .hold_o          (hold_o),
  .break_jump_o    (break_jump_o),
  .fetch_restart_o (fetch_restart_o),
  .rd_req_o        (rd_req_o)
);

// File: tb/core_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_hold_ctrl_tb_top;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] RADDR = 16'hA5C0;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n, rst_req, dbg_req, pipe_empty, paused, step, rd_ack;
  logic rst_taken, dbg_ack, hold, brk, restart, rd_req;
  logic [AW-1:0] rd_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_hold_ctrl #(.ADDR_W(AW), .RST_ADDR(RADDR), .PERIOD(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .dbg_req_i(dbg_req),
    .pipe_empty_i(pipe_empty), .dbg_paused_i(paused), .step_i(step),
    .rd_ack_i(rd_ack), .rst_taken_o(rst_taken), .dbg_ack_o(dbg_ack),
    .hold_o(hold), .break_jump_o(brk), .fetch_restart_o(restart),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; rst_req = 0; dbg_req = 0; pipe_empty = 0;
    paused = 0; step = 0; rd_ack = 0;
    #1;
    chk("R1 reset hold", {31'd0, hold}, 0);
    chk("R1 reset outputs", {26'd0, rst_taken, dbg_ack, brk, restart, rd_req, hold}, 0);
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R7: frozen core ignores the request
    paused = 1; rst_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7 frozen ignore", {31'd0, hold}, 0);
    end
    // R8: single step releases the deferred request
    step = 1; tick(); step = 0;
    chk("R8 step acts", {31'd0, hold}, 1);
    paused = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 drain hold", {30'd0, hold, rst_taken}, 2);
    end
    pipe_empty = 1; tick(); pipe_empty = 0;
    // R3/R4/R5: periodic acknowledge and held dummy read, k=0 is entry
    begin
      bit pend = 0;
      for (int k = 0; k < 3 * P; k++) begin
        logic et, er;
        et = (k % P == 0);
        er = et | pend;
        chk("R4 taken period", {31'd0, rst_taken}, {31'd0, et});
        chk("R5 rd req", {31'd0, rd_req}, {31'd0, er});
        chk("R5 rd addr", {16'd0, rd_addr}, {16'd0, RADDR});
        rd_ack = (k == 2) || (k == 7) || (k == 10);
        pend = er & ~rd_ack;
        tick();
      end
      rd_ack = 0;
    end
    // R6: release
    rst_req = 0; tick();
    chk("R6 release", {29'd0, hold, restart, rd_req}, 3'b010);
    tick();
    chk("R6 restart single", {31'd0, restart}, 0);

    // R11: drop during drain
    rst_req = 1; tick();
    chk("R11 drain start", {31'd0, hold}, 1);
    rst_req = 0; tick();
    chk("R11 abandon", {29'd0, hold, restart, rst_taken}, 0);
    tick();
    chk("R11 no restart", {30'd0, restart, rst_taken}, 0);

    // R3 sweep over drain lengths
    for (int d = 0; d < 4; d++) begin
      rst_req = 1; tick();
      for (int j = 0; j < d; j++) begin
        tick();
        chk("R3 wait empty", {30'd0, hold, rst_taken}, 2);
      end
      pipe_empty = 1; tick(); pipe_empty = 0;
      chk("R3 entry pulse", {30'd0, hold, rst_taken}, 3);
      tick();
      chk("R3 single cycle", {31'd0, rst_taken}, 0);
      rst_req = 0; tick(); tick();
    end

    // R8: resume with dbg_paused low after deferral
    paused = 1; rst_req = 1; tick(); tick();
    chk("R7 deferred", {31'd0, hold}, 0);
    paused = 0; tick();
    chk("R8 resume acts", {31'd0, hold}, 1);
    rst_req = 0; tick(); tick();

    // R9: debug pause
    dbg_req = 1; tick();
    chk("R9 break pulse", {30'd0, brk, dbg_ack}, 3);
    tick();
    chk("R9 ack held", {30'd0, brk, dbg_ack}, 1);
    tick();
    chk("R9 ack held 2", {31'd0, dbg_ack}, 1);
    dbg_req = 0; tick();
    chk("R9 ack drop", {31'd0, dbg_ack}, 0);

    // R10: paused core ignores debug request
    paused = 1; dbg_req = 1;
    tick(); tick();
    chk("R10 paused ignore", {30'd0, brk, dbg_ack}, 0);
    paused = 0; dbg_req = 0; tick();

    // R12: simultaneous requests
    rst_req = 1; dbg_req = 1; tick();
    chk("R12 reset wins", {30'd0, hold, dbg_ack}, 2);
    pipe_empty = 1; tick();
    chk("R12 entry", {29'd0, hold, dbg_ack, rst_taken}, 3'b101);
    pipe_empty = 0; tick();

    // R1: global reset in the middle of reset
    #1 rst_n = 1'b0; #0.5;
    chk("R1 async clear", {26'd0, rst_taken, dbg_ack, brk, restart, rd_req, hold}, 0);
    rst_req = 0; dbg_req = 0;
    tick();
    rst_n = 1'b1; tick();
    chk("R1 after reset", {31'd0, hold}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule